// File: doc/BRIEF.md
# Seven-Slot Pixel Lane Serializer

This block converts one colour pixel per pixel period into seven-bit groups on up to four serial data lanes, with a companion lane clock that frames each group. It runs on one fast clock at seven times the pixel rate. A one-cycle strobe loads a pixel (8-bit red, green and blue, plus data-enable, vertical sync, horizontal sync and one spare control bit) into per-lane shift registers. The seven slots of every lane then leave one per fast cycle, slot 0 first.

A two-bit map select picks how pixel bits are spread over lanes and slots. The choices are an 18-bit three-lane mode, a 24-bit four-lane mode with the colour MSB pairs on lane 3, and a 24-bit four-lane mode with the colour LSB pairs on lane 3. The select is captured together with the pixel, so a change while a pixel is shifting does not split it. A parameter, `ZERO_CTRL`, forces the sync, enable and spare slots to 0 for links where those bits are left undefined.

The sequencer has two states. `ST_IDLE` holds all outputs low. Transition LOAD (strobe seen) enters `ST_RUN` at slot 0. In `ST_RUN`, transition ADVANCE steps the slot counter from 0 to 6. At slot 6, transition RELOAD (strobe present) stays in `ST_RUN` at slot 0 with the next pixel. Transition DRAIN (no strobe) returns to `ST_IDLE` and clears the outputs.

Top module: `lvds_pix_serializer`

## Requirements
- R1: After reset, `lane_o` is 4'b0000, `lclk_o` is 0, and the block is idle. An asynchronous reset during shifting clears the outputs at once.
- R2: A strobe sampled while the block is idle, or while slot 6 is on the outputs, loads the pixel. Slot 0 appears on the outputs right after that clock edge, and slots 1 to 6 follow on the next six edges.
- R3: With `map_sel` 0, or the reserved value 3 (18-bit), only bits 7:2 of each colour are used. The slots, listed from slot 0 to slot 6, are:
  - lane 0: g2, r7, r6, r5, r4, r3, r2
  - lane 1: b3, b2, g7, g6, g5, g4, g3
  - lane 2: de, vs, hs, b7, b6, b5, b4
  - lane 3: held at 0
- R4: With `map_sel` 1, the slots from slot 0 to slot 6 are:
  - lane 0: g0, r5, r4, r3, r2, r1, r0
  - lane 1: b1, b0, g5, g4, g3, g2, g1
  - lane 2: de, vs, hs, b5, b4, b3, b2
  - lane 3: ctl, b7, b6, g7, g6, r7, r6
- R5: With `map_sel` 2, lanes 0 to 2 match R3. Lane 3 carries ctl, b1, b0, g1, g0, r1, r0 from slot 0 to slot 6.
- R6: de, vs and hs always sit in slots 0, 1 and 2 of lane 2, and ctl sits in slot 0 of lane 3. With `ZERO_CTRL`=1 these four slots are 0, and all other slots are unchanged.
- R7: While shifting, `lclk_o` follows 1,1,0,0,0,1,1 over slots 0 to 6. It is 0 while idle.
- R8: A strobe that arrives while slots 0 to 5 are on the outputs is ignored. The pixel in flight completes unchanged.
- R9: `map_sel` and the pixel inputs are sampled only at a load. Changing them mid-pixel does not alter the slots still to be sent.
- R10: If no strobe is present while slot 6 is on the outputs, then after the next edge all lanes and `lclk_o` are 0, and they stay 0 until the next strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, seven times the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_stb | input | 1 | Pixel load strobe |
| map_sel | input | 2 | Bit mapping: 0 18-bit, 1 24-bit MSBs on lane 3, 2 24-bit LSBs on lane 3, 3 as 0 |
| red | input | 8 | Red component |
| grn | input | 8 | Green component |
| blu | input | 8 | Blue component |
| de_i | input | 1 | Data enable |
| vs_i | input | 1 | Vertical sync |
| hs_i | input | 1 | Horizontal sync |
| ctl_i | input | 1 | Spare control bit |
| lane_o | output | 4 | Serial data lanes, bit n is lane n |
| lclk_o | output | 1 | Lane clock framing each seven-slot group |

## Verification
The hardest situation to reach is a disturbance in the middle of a pixel. The strobe, the map select and every pixel input change while slot 2 is on the lanes, and the remaining slots must still come from the captured pixel. The bench reaches this by raising the strobe and inverting the map select and colour inputs two slots into a pixel, then lowering the strobe one slot later. The rest of that pixel is compared against the original vector. A second instance built with `ZERO_CTRL`=1 shares the inputs, so every pixel checks the masked control slots as well. A stretch with no strobe after slot 6 shows the DRAIN transition and the LOAD that restarts shifting from idle.

// File: rtl/lvser_pkg.sv
package lvser_pkg;

    localparam int SLOT_N = 7;
    localparam int LANE_N = 4;
    localparam int PIX_W  = 8;
    localparam int SLOT_W = $clog2(SLOT_N);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOT_N - 1);

    // lane clock level per slot, bit s = slot s
    localparam logic [SLOT_N-1:0] CLK_PAT = 7'b1100011;

    typedef enum logic [1:0] {
        MAP_N18   = 2'd0,
        MAP_STD24 = 2'd1,
        MAP_ALT24 = 2'd2,
        MAP_RSV   = 2'd3
    } map_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    typedef enum logic [1:0] {
        CMD_HOLD  = 2'd0,
        CMD_LOAD  = 2'd1,
        CMD_SHIFT = 2'd2,
        CMD_CLEAR = 2'd3
    } shift_cmd_e;

endpackage

// File: rtl/lvser_slot_map.sv
module lvser_slot_map
    import lvser_pkg::*;
#(
    parameter bit ZERO_CTRL = 1'b0
) (
    input  map_mode_e                        mode,
    input  logic [PIX_W-1:0]                 red,
    input  logic [PIX_W-1:0]                 grn,
    input  logic [PIX_W-1:0]                 blu,
    input  logic                             de,
    input  logic                             vs,
    input  logic                             hs,
    input  logic                             ctl,
    output logic [LANE_N-1:0][SLOT_N-1:0]    words
);

    logic de_m, vs_m, hs_m, ctl_m;

    generate
        if (ZERO_CTRL) begin : g_mask
            assign de_m  = 1'b0;
            assign vs_m  = 1'b0;
            assign hs_m  = 1'b0;
            assign ctl_m = 1'b0;
        end else begin : g_pass
            assign de_m  = de;
            assign vs_m  = vs;
            assign hs_m  = hs;
            assign ctl_m = ctl;
        end
    endgenerate

    always_comb begin
        int ofs;
        int hi;
        ofs = (mode == MAP_STD24) ? 0 : 2;
        hi  = (mode == MAP_ALT24) ? 0 : 6;
        words = '0;

        // lane 0: one green bit then six red bits, descending
        words[0][0] = grn[ofs];
        for (int s = 1; s < SLOT_N; s++) begin
            words[0][s] = red[6 - s + ofs];
        end

        // lane 1: two blue bits then five green bits, descending
        words[1][0] = blu[1 + ofs];
        words[1][1] = blu[ofs];
        for (int s = 2; s < SLOT_N; s++) begin
            words[1][s] = grn[7 - s + ofs];
        end

        // lane 2: enable and syncs then four blue bits
        words[2][0] = de_m;
        words[2][1] = vs_m;
        words[2][2] = hs_m;
        for (int s = 3; s < SLOT_N; s++) begin
            words[2][s] = blu[8 - s + ofs];
        end

        // lane 3: control then the remaining pair of each colour
        if (mode == MAP_STD24 || mode == MAP_ALT24) begin
            words[3][0] = ctl_m;
            words[3][1] = blu[hi + 1];
            words[3][2] = blu[hi];
            words[3][3] = grn[hi + 1];
            words[3][4] = grn[hi];
            words[3][5] = red[hi + 1];
            words[3][6] = red[hi];
        end
    end

endmodule

// File: rtl/lvser_seq_fsm.sv
module lvser_seq_fsm
    import lvser_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pix_stb,
    output shift_cmd_e         cmd,
    output seq_state_e         state_o,
    output logic [SLOT_W-1:0]  slot_o
);

    seq_state_e        state_q, state_d;
    logic [SLOT_W-1:0] slot_q, slot_d;

    always_comb begin
        state_d = state_q;
        slot_d  = slot_q;
        unique case (state_q)
            ST_IDLE: begin
                if (pix_stb) begin
                    state_d = ST_RUN;
                    slot_d  = '0;
                end
            end
            ST_RUN: begin
                if (slot_q == SLOT_LAST) begin
                    slot_d  = '0;
                    state_d = pix_stb ? ST_RUN : ST_IDLE;
                end else begin
                    slot_d = slot_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                slot_d  = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
        end
    end

    always_comb begin
        cmd = CMD_HOLD;
        unique case (state_q)
            ST_IDLE: cmd = pix_stb ? CMD_LOAD : CMD_HOLD;
            ST_RUN: begin
                if (slot_q == SLOT_LAST) begin
                    cmd = pix_stb ? CMD_LOAD : CMD_CLEAR;
                end else begin
                    cmd = CMD_SHIFT;
                end
            end
            default: cmd = CMD_CLEAR;
        endcase
    end

    assign state_o = state_q;
    assign slot_o  = slot_q;

    AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q <= SLOT_LAST);  // R2
    AST_MID_STROBE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && slot_q != SLOT_LAST) |=>
        (state_q == ST_RUN && slot_q == $past(slot_q) + 1'b1));  // R8
    AST_DRAIN_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && slot_q == SLOT_LAST && !pix_stb) |=> (state_q == ST_IDLE));  // R10
    AST_LOAD_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && pix_stb) |=> (state_q == ST_RUN && slot_q == '0));  // R2

endmodule

// File: rtl/lvser_slot_shreg.sv
module lvser_slot_shreg
    import lvser_pkg::*;
#(
    parameter int W = SLOT_N
) (
    input  logic          clk,
    input  logic          rst_n,
    input  shift_cmd_e    cmd,
    input  logic [W-1:0]  word,
    output logic          bit_o
);

    logic         bit_q;
    logic [W-2:0] rest_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q  <= 1'b0;
            rest_q <= '0;
        end else begin
            unique case (cmd)
                CMD_LOAD: begin
                    bit_q  <= word[0];
                    rest_q <= word[W-1:1];
                end
                CMD_SHIFT: begin
                    bit_q  <= rest_q[0];
                    rest_q <= rest_q >> 1;
                end
                CMD_CLEAR: begin
                    bit_q  <= 1'b0;
                    rest_q <= '0;
                end
                default: ;
            endcase
        end
    end

    assign bit_o = bit_q;

endmodule

// File: rtl/lvds_pix_serializer.sv
module lvds_pix_serializer
    import lvser_pkg::*;
#(
    parameter bit ZERO_CTRL = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_stb,
    input  logic [1:0]        map_sel,
    input  logic [PIX_W-1:0]  red,
    input  logic [PIX_W-1:0]  grn,
    input  logic [PIX_W-1:0]  blu,
    input  logic              de_i,
    input  logic              vs_i,
    input  logic              hs_i,
    input  logic              ctl_i,
    output logic [LANE_N-1:0] lane_o,
    output logic              lclk_o
);

    shift_cmd_e                     cmd;
    seq_state_e                     state;
    logic [SLOT_W-1:0]              slot;
    logic [LANE_N-1:0][SLOT_N-1:0]  words;
    map_mode_e                      mode_in;
    map_mode_e                      mode_q;

    assign mode_in = map_mode_e'(map_sel);

    lvser_seq_fsm u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .pix_stb (pix_stb),
        .cmd     (cmd),
        .state_o (state),
        .slot_o  (slot)
    );

    lvser_slot_map #(.ZERO_CTRL(ZERO_CTRL)) u_map (
        .mode  (mode_in),
        .red   (red),
        .grn   (grn),
        .blu   (blu),
        .de    (de_i),
        .vs    (vs_i),
        .hs    (hs_i),
        .ctl   (ctl_i),
        .words (words)
    );

    generate
        for (genvar ln = 0; ln < LANE_N; ln++) begin : g_lane
            lvser_slot_shreg #(.W(SLOT_N)) u_lane (
                .clk   (clk),
                .rst_n (rst_n),
                .cmd   (cmd),
                .word  (words[ln]),
                .bit_o (lane_o[ln])
            );
        end
    endgenerate

    lvser_slot_shreg #(.W(SLOT_N)) u_lclk (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd   (cmd),
        .word  (CLK_PAT),
        .bit_o (lclk_o)
    );

    // map mode of the pixel currently on the lanes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MAP_N18;
        end else if (cmd == CMD_LOAD) begin
            mode_q <= mode_in;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (lane_o == '0 && !lclk_o));  // R10
    AST_CLK_HIGH_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && slot == '0) |-> lclk_o);  // R7
    AST_CLK_LOW_MID: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && slot == SLOT_W'(3)) |-> !lclk_o);  // R7
    AST_LANE3_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && (mode_q == MAP_N18 || mode_q == MAP_RSV)) |-> !lane_o[3]);  // R3
    AST_CTRL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (ZERO_CTRL && state == ST_RUN && slot <= SLOT_W'(2)) |-> !lane_o[2]);  // R6

endmodule

// File: tb/lvds_pix_serializer_tb_top.sv
`timescale 1ns/1ps
module lvds_pix_serializer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       pix_stb;
    logic [1:0] map_sel;
    logic [7:0] red, grn, blu;
    logic       de_i, vs_i, hs_i, ctl_i;
    logic [3:0] lane_a, lane_z;
    logic       lclk_a, lclk_z;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 0;

    localparam logic [6:0] CLK_EXP = 7'b1100011;

    // {map_sel, red, grn, blu, de, vs, hs, ctl}
    localparam logic [29:0] VEC [8] = '{
        {2'd1, 8'hA5, 8'h3C, 8'h0F, 4'b1010},
        {2'd2, 8'hA5, 8'h3C, 8'h0F, 4'b0101},
        {2'd0, 8'hFF, 8'h00, 8'h81, 4'b1111},
        {2'd1, 8'h01, 8'h80, 8'h7E, 4'b0001},
        {2'd2, 8'h01, 8'h80, 8'h7E, 4'b1000},
        {2'd3, 8'h5A, 8'hC3, 8'h24, 4'b0110},
        {2'd1, 8'hFF, 8'hFF, 8'hFF, 4'b1111},
        {2'd2, 8'h00, 8'h00, 8'h00, 4'b0000}
    };

    always #5 clk = ~clk;

    lvds_pix_serializer #(.ZERO_CTRL(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .pix_stb(pix_stb), .map_sel(map_sel),
        .red(red), .grn(grn), .blu(blu), .de_i(de_i), .vs_i(vs_i),
        .hs_i(hs_i), .ctl_i(ctl_i), .lane_o(lane_a), .lclk_o(lclk_a)
    );

    lvds_pix_serializer #(.ZERO_CTRL(1'b1)) dut_z_i (
        .clk(clk), .rst_n(rst_n), .pix_stb(pix_stb), .map_sel(map_sel),
        .red(red), .grn(grn), .blu(blu), .de_i(de_i), .vs_i(vs_i),
        .hs_i(hs_i), .ctl_i(ctl_i), .lane_o(lane_z), .lclk_o(lclk_z)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h at %0t", rq, act, exp, $time);
        end
    endtask

    // expected lane words {w3,w2,w1,w0}, bit s of each word = slot s
    function automatic logic [27:0] expect_words(input logic [29:0] v, input bit zc);
        logic [1:0] m;
        logic [7:0] r, g, b;
        logic de, vs, hs, ct;
        logic [6:0] w0, w1, w2, w3;
        {m, r, g, b, de, vs, hs, ct} = v;
        if (zc) begin
            de = 0; vs = 0; hs = 0; ct = 0;
        end
        if (m == 2'd1) begin
            w0 = {r[0], r[1], r[2], r[3], r[4], r[5], g[0]};
            w1 = {g[1], g[2], g[3], g[4], g[5], b[0], b[1]};
            w2 = {b[2], b[3], b[4], b[5], hs, vs, de};
            w3 = {r[6], r[7], g[6], g[7], b[6], b[7], ct};
        end else begin
            w0 = {r[2], r[3], r[4], r[5], r[6], r[7], g[2]};
            w1 = {g[3], g[4], g[5], g[6], g[7], b[2], b[3]};
            w2 = {b[4], b[5], b[6], b[7], hs, vs, de};
            w3 = (m == 2'd2) ? {r[0], r[1], g[0], g[1], b[0], b[1], ct} : 7'd0;
        end
        return {w3, w2, w1, w0};
    endfunction

    function automatic string mode_req(input logic [1:0] m);
        if (m == 2'd1) return "R4";
        if (m == 2'd2) return "R5";
        return "R3";
    endfunction

    // drive one pixel with a strobe, then check all seven slots; ends at
    // the negedge where slot 6 is on the outputs
    task automatic send_px(input logic [29:0] v, input bit disturb, input string rq);
        logic [27:0] e, ez;
        string lbl;
        e  = expect_words(v, 1'b0);
        ez = expect_words(v, 1'b1);
        {map_sel, red, grn, blu, de_i, vs_i, hs_i, ctl_i} = v;
        pix_stb = 1'b1;
        @(posedge clk);
        @(negedge clk);
        pix_stb = 1'b0;
        for (int s = 0; s < 7; s++) begin
            lbl = (disturb && s > 2) ? "R9" : rq;
            chk(lbl, {28'd0, lane_a}, {28'd0, e[21+s], e[14+s], e[7+s], e[s]});
            chk("R6", {28'd0, lane_z}, {28'd0, ez[21+s], ez[14+s], ez[7+s], ez[s]});
            chk((disturb && s > 2) ? "R8" : "R7", {31'd0, lclk_a}, {31'd0, CLK_EXP[s]});
            if (disturb && s == 2) begin
                pix_stb = 1'b1;
                map_sel = map_sel ^ 2'b11;
                red = ~red; grn = ~grn; blu = ~blu;
                de_i = ~de_i; vs_i = ~vs_i; hs_i = ~hs_i; ctl_i = ~ctl_i;
            end
            if (disturb && s == 3) pix_stb = 1'b0;
            if (s < 6) begin
                @(posedge clk);
                @(negedge clk);
            end
        end
    endtask

    initial begin
        rst_n = 1'b0; pix_stb = 1'b0; map_sel = 2'd0;
        red = '0; grn = '0; blu = '0;
        de_i = 0; vs_i = 0; hs_i = 0; ctl_i = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", {27'd0, lane_a, lclk_a}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", {27'd0, lane_a, lclk_a}, 32'd0);

        // table walk, back to back pixels
        for (int i = 0; i < 8; i++) begin
            send_px(VEC[i], 1'b0, mode_req(VEC[i][29:28]));
        end

        // mid-pixel strobe and input changes
        send_px(VEC[0], 1'b1, "R4");
        send_px(VEC[4], 1'b1, "R5");

        // drain to idle when no strobe follows slot 6
        @(posedge clk);
        @(negedge clk);
        chk("R10", {27'd0, lane_a, lclk_a}, 32'd0);
        repeat (4) begin
            @(posedge clk);
            @(negedge clk);
            chk("R10", {27'd0, lane_a, lclk_z}, 32'd0);
        end

        // restart from idle
        send_px(VEC[6], 1'b0, "R2");
        @(posedge clk);
        @(negedge clk);
        chk("R10", {27'd0, lane_a, lclk_a}, 32'd0);

        // reset in the middle of a pixel
        {map_sel, red, grn, blu, de_i, vs_i, hs_i, ctl_i} = VEC[6];
        pix_stb = 1'b1;
        @(posedge clk);
        @(negedge clk);
        pix_stb = 1'b0;
        chk("R2", {27'd0, lane_a, lclk_a}, {27'd0, 4'b1111, 1'b1});
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1", {27'd0, lane_a, lclk_a}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", {27'd0, lane_a, lclk_a}, 32'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule